// File: doc/BRIEF.md
# Register Write-Lock Sequencer

This block sits in front of a bank of timekeeping registers and a small retained RAM. It decides, cycle by cycle, whether a bus access to that address window may proceed. While the bank is unlocked, writes inside the window pass through a write-enable gate. While it is locked, every access to the window is refused. A refused access raises a one-cycle transfer-error pulse in the same cycle as the access.

Software controls the lock through a 2-bit lock field in the control register. Writes to that field are always taken, even while the bank is locked. One code locks the bank. Unlocking takes a fixed key of four successive field writes.

A once-per-second tick drives two timeouts that lock the bank without software:

- After power-on, the bank locks if software has not locked it in time.
- After each unlock, the bank locks again a short time later.

Top module: `wlock_guard`

## Requirements
- R1: After reset the bank is unlocked (`locked` = 0), and an idle bus gives `xfer_err` = 0.
- R2: A write to the control register whose lock field (bits LOCK_LSB+1:LOCK_LSB) holds 2'b10, and that does not complete the key, sets `locked` to 1 from the next cycle on.
- R3: Four successive lock-field writes of 2'b00, 2'b01, 2'b11, 2'b10 clear `locked` from the cycle after the last write. No other sequence of four writes starting from the idle key state unlocks the bank.
- R4: A lock-field write that is not the next expected key value sends the key tracker back to its start. If that write is 2'b00, it counts as the first key step of a new attempt.
- R5: Writes to any address other than the control register neither advance the key tracker nor reset it.
- R6: If the bank has not been locked by then, it locks on the BOOT_SECS-th (default 15) rising edge of `tick_1hz` after reset, and not before. A tick held high for several clock cycles counts once.
- R7: After an unlock, the bank locks on the RELOCK_SECS-th (default 2) rising tick edge. A new unlock restarts this count, and a software lock clears it.
- R8: While locked, any read or write in the window raises `xfer_err` in that cycle and keeps `prot_wr_en` low. Writes to the control register are exempt from the error.
- R9: While unlocked, a write in the window (base PROT_BASE, PROT_SPAN addresses) raises `prot_wr_en` in that cycle with no error. Accesses outside the window raise neither output.
- R10: If the key completes in the same cycle as the relock timeout, the unlock wins, and the relock count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| tick_1hz | input | 1 | Seconds tick, synchronous to clk |
| prot_wr_en | output | 1 | Write enable passed to the protected registers |
| xfer_err | output | 1 | Transfer-error pulse for a refused access |
| locked | output | 1 | Current lock state |

## Verification
The collision that matters is the last key write landing in the same clock cycle as the tick edge that expires the relock timer. The bench provokes it by raising the tick and the final 2'b10 write on the same falling edge, so that both are sampled at the same rising edge. The bench judges the result by requiring the bank to stay unlocked afterwards and then lock on exactly the second tick that follows. A smaller collision is also covered: a control-register write made while the bank is locked must reach the key tracker and raise no error.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_S1   = 2'd1,
      KS_S2   = 2'd2,
      KS_S3   = 2'd3
   } key_st_e;

   localparam logic [1:0] CODE_LOCK = 2'b10;
   localparam logic [1:0] KEY_1     = 2'b00;
   localparam logic [1:0] KEY_2     = 2'b01;
   localparam logic [1:0] KEY_3     = 2'b11;
   localparam logic [1:0] KEY_4     = 2'b10;

endpackage

// File: rtl/wlock_keyseq.sv
module wlock_keyseq
   import wlock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fld_wr,
   input  logic [1:0] fld_val,
   output logic       key_done
);

   key_st_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      key_done = 1'b0;
      if (fld_wr) begin
         unique case (st_q)
            KS_S3:   if (fld_val == KEY_4) begin
                        key_done = 1'b1;
                        st_d     = KS_IDLE;
                     end else st_d = (fld_val == KEY_1) ? KS_S1 : KS_IDLE;
            KS_S2:   st_d = (fld_val == KEY_3) ? KS_S3 :
                            (fld_val == KEY_1) ? KS_S1 : KS_IDLE;
            KS_S1:   st_d = (fld_val == KEY_2) ? KS_S2 :
                            (fld_val == KEY_1) ? KS_S1 : KS_IDLE;
            default: st_d = (fld_val == KEY_1) ? KS_S1 : KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/wlock_sectimer.sv
module wlock_sectimer #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic tick_rise,
   output logic expire
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   if (LIMIT < 1) begin : g_bad_limit
      $error("wlock_sectimer: LIMIT must be at least 1");
   end

   assign expire = run && tick_rise && !restart && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart || !run)    cnt_q <= '0;
      else if (tick_rise)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/wlock_guard.sv
module wlock_guard
   import wlock_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int PROT_BASE   = 0,
   parameter int PROT_SPAN   = 32,
   parameter int CTRL_OFS    = 0,
   parameter int LOCK_LSB    = 0,
   parameter int BOOT_SECS   = 15,
   parameter int RELOCK_SECS = 2,
   parameter bit TICK_EDGE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              tick_1hz,
   output logic              prot_wr_en,
   output logic              xfer_err,
   output logic              locked
);

   localparam logic [ADDR_W:0]   BASE_X    = (ADDR_W+1)'(PROT_BASE);
   localparam logic [ADDR_W:0]   SPAN_X    = (ADDR_W+1)'(PROT_SPAN);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(PROT_BASE + CTRL_OFS);

   if (PROT_SPAN < 1 || PROT_BASE + PROT_SPAN > (1 << ADDR_W)) begin : g_bad_window
      $error("wlock_guard: protected window does not fit the address space");
   end
   if (CTRL_OFS < 0 || CTRL_OFS >= PROT_SPAN) begin : g_bad_ctrl
      $error("wlock_guard: control register must lie inside the window");
   end
   if (LOCK_LSB < 0 || LOCK_LSB + 2 > DATA_W) begin : g_bad_field
      $error("wlock_guard: lock field must fit in the data word");
   end

   // ---- address decode ----
   logic [ADDR_W:0] addr_off;
   logic            in_space, is_ctrl, fld_wr;
   logic [1:0]      fld_val;
   logic            unused_wdata;

   assign addr_off     = {1'b0, bus_addr} - BASE_X;
   assign in_space     = addr_off < SPAN_X;
   assign is_ctrl      = bus_addr == CTRL_ADDR;
   assign fld_wr       = bus_wr && is_ctrl;
   assign fld_val      = bus_wdata[LOCK_LSB +: 2];
   assign unused_wdata = ^bus_wdata;

   // ---- tick edge ----
   logic tick_rise;
   if (TICK_EDGE) begin : g_tick_edge
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= tick_1hz;
      end
      assign tick_rise = tick_1hz && !tick_q;
   end else begin : g_tick_pulse
      assign tick_rise = tick_1hz;
   end

   // ---- key tracker ----
   logic key_done;
   wlock_keyseq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fld_wr   (fld_wr),
      .fld_val  (fld_val),
      .key_done (key_done)
   );

   // ---- timeouts ----
   logic locked_q, locked_d;
   logic boot_act_q, relock_arm_q;
   logic boot_exp, relock_exp;

   wlock_sectimer #(.LIMIT(BOOT_SECS)) u_boot (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (boot_act_q),
      .restart   (1'b0),
      .tick_rise (tick_rise),
      .expire    (boot_exp)
   );

   wlock_sectimer #(.LIMIT(RELOCK_SECS)) u_relock (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (relock_arm_q),
      .restart   (key_done),
      .tick_rise (tick_rise),
      .expire    (relock_exp)
   );

   // ---- lock state ----
   logic lock_req;
   assign lock_req = fld_wr && (fld_val == CODE_LOCK) && !key_done;

   always_comb begin
      if (key_done)                             locked_d = 1'b0;
      else if (lock_req || boot_exp || relock_exp) locked_d = 1'b1;
      else                                      locked_d = locked_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q     <= 1'b0;
         boot_act_q   <= 1'b1;
         relock_arm_q <= 1'b0;
      end else begin
         locked_q     <= locked_d;
         boot_act_q   <= boot_act_q && !locked_d && !key_done;
         relock_arm_q <= key_done || (relock_arm_q && !locked_d);
      end
   end

   // ---- bus outputs ----
   assign locked     = locked_q;
   assign prot_wr_en = bus_wr && in_space && !locked_q;
   assign xfer_err   = (bus_wr || bus_rd) && in_space && locked_q && !fld_wr;

endmodule

// File: rtl/wlock_guard_chk.sv
module wlock_guard_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PROT_BASE = 0,
   parameter int PROT_SPAN = 32,
   parameter int CTRL_OFS  = 0,
   parameter int LOCK_LSB  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              prot_wr_en,
   input logic              xfer_err,
   input logic              locked,
   input logic              key_done
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(PROT_BASE + CTRL_OFS);

   logic outside, ctl_wr, ctl_wr10, unused_bits;
   assign outside     = (int'(bus_addr) < PROT_BASE) || (int'(bus_addr) >= PROT_BASE + PROT_SPAN);
   assign ctl_wr      = bus_wr && (bus_addr == CTRL_A);
   assign ctl_wr10    = ctl_wr && (bus_wdata[LOCK_LSB +: 2] == 2'b10);
   assign unused_bits = ^bus_wdata;

   p_lock_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr10 && !key_done |=> locked);

   p_key_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |=> !locked);

   p_unlock_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(key_done));

   p_ctrl_exempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |-> !xfer_err);

   p_err_when_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> locked && (bus_wr || bus_rd));

   p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !prot_wr_en);

   p_outside_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      outside |-> !xfer_err && !prot_wr_en);

endmodule

bind wlock_guard wlock_guard_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PROT_BASE (PROT_BASE),
   .PROT_SPAN (PROT_SPAN),
   .CTRL_OFS  (CTRL_OFS),
   .LOCK_LSB  (LOCK_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .prot_wr_en (prot_wr_en),
   .xfer_err   (xfer_err),
   .locked     (locked),
   .key_done   (key_done)
);

// File: tb/sim_wlock_guard.sv
`timescale 1ns/1ps
module sim_wlock_guard;

   localparam logic [7:0] CTRL = 8'h00;
   localparam logic [7:0] INW  = 8'h05;
   localparam logic [7:0] OUTW = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       tick_1hz = 1'b0;
   logic       prot_wr_en, xfer_err, locked;

   always #2.5 clk = ~clk;

   wlock_guard u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tick_1hz(tick_1hz),
      .prot_wr_en(prot_wr_en), .xfer_err(xfer_err), .locked(locked)
   );

   int n_run = 0, n_fail = 0;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [7:0] a, input logic w, input logic r,
                      input logic [7:0] d, output logic err, output logic we);
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      #1;
      err = xfer_err; we = prot_wr_en;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wctl(input logic [1:0] v);
      logic e, w;
      acc(CTRL, 1'b1, 1'b0, {6'b0, v}, e, w);
   endtask

   task automatic tick1();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic prep();   // idle tracker, bank locked
      wctl(2'b11); wctl(2'b11); wctl(2'b10);
   endtask

   task automatic key();
      wctl(2'b00); wctl(2'b01); wctl(2'b11); wctl(2'b10);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic e, w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 locked after reset", locked, 1'b0);
      chk("R1 no error idle", xfer_err, 1'b0);

      acc(INW, 1'b1, 1'b0, 8'h55, e, w);
      chk("R9 unlocked write gate", w, 1'b1);
      chk("R9 unlocked write no error", e, 1'b0);
      acc(OUTW, 1'b1, 1'b0, 8'h55, e, w);
      chk("R9 outside write gate", w, 1'b0);
      chk("R9 outside write error", e, 1'b0);

      // R6 boot timeout
      for (int i = 0; i < 14; i++) tick1();
      chk("R6 still unlocked after 14 ticks", locked, 1'b0);
      @(negedge clk); tick_1hz = 1'b1;
      repeat (5) @(negedge clk);
      tick_1hz = 1'b0;
      chk("R6 locked at tick 15", locked, 1'b1);

      // R8 locked accesses
      acc(INW, 1'b1, 1'b0, 8'hAA, e, w);
      chk("R8 locked write error", e, 1'b1);
      chk("R8 locked write gate", w, 1'b0);
      acc(INW, 1'b0, 1'b1, 8'h00, e, w);
      chk("R8 locked read error", e, 1'b1);
      acc(CTRL, 1'b1, 1'b0, 8'h00, e, w);
      chk("R8 control write exempt", e, 1'b0);
      acc(OUTW, 1'b0, 1'b1, 8'h00, e, w);
      chk("R9 outside read while locked", e, 1'b0);

      // R3 sweep of all four-write sequences from idle
      for (int i = 0; i < 256; i++) begin
         prep();
         wctl(i[7:6]); wctl(i[5:4]); wctl(i[3:2]); wctl(i[1:0]);
         chk($sformatf("R3 sequence %02h", i), locked, (i != 8'h1E));
      end

      // R4 one stray write then the key always unlocks
      for (int x = 0; x < 4; x++) begin
         prep();
         wctl(x[1:0]); key();
         chk($sformatf("R4 prefix %0d then key", x), locked, 1'b0);
      end
      prep();
      wctl(2'b00); wctl(2'b01); wctl(2'b01); wctl(2'b11); wctl(2'b10);
      chk("R4 broken key stays locked", locked, 1'b1);
      prep();
      wctl(2'b00); wctl(2'b01); wctl(2'b00); wctl(2'b01); wctl(2'b11); wctl(2'b10);
      chk("R4 restart on 00", locked, 1'b0);

      // R5 other addresses ignored by the tracker
      prep();
      wctl(2'b00);
      acc(INW, 1'b1, 1'b0, 8'h01, e, w);
      acc(INW, 1'b1, 1'b0, 8'h03, e, w);
      wctl(2'b01); wctl(2'b11); wctl(2'b10);
      chk("R5 foreign writes do not reset", locked, 1'b0);
      prep();
      wctl(2'b00);
      acc(INW, 1'b1, 1'b0, 8'h01, e, w);
      acc(INW, 1'b1, 1'b0, 8'h03, e, w);
      acc(INW, 1'b1, 1'b0, 8'h02, e, w);
      wctl(2'b10);
      chk("R5 foreign writes do not advance", locked, 1'b1);

      // R7 relock timeout (bank locked now)
      key();
      tick1();
      chk("R7 unlocked after 1 tick", locked, 1'b0);
      tick1();
      chk("R7 relocked after 2 ticks", locked, 1'b1);
      key(); tick1(); key(); tick1();
      chk("R7 new unlock restarts count", locked, 1'b0);
      tick1();
      chk("R7 relock after restart", locked, 1'b1);
      key(); tick1();
      wctl(2'b10);
      chk("R2 lock code from unlocked", locked, 1'b1);
      key(); tick1();
      chk("R7 software lock cleared count", locked, 1'b0);
      tick1();
      chk("R7 relock after cleared count", locked, 1'b1);

      // R10 key completion coincides with relock expiry
      key(); tick1();
      wctl(2'b00); wctl(2'b01); wctl(2'b11);
      @(negedge clk);
      bus_addr = CTRL; bus_wr = 1'b1; bus_wdata = 8'h02; tick_1hz = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      @(negedge clk);
      tick_1hz = 1'b0;
      chk("R10 unlock wins over expiry", locked, 1'b0);
      tick1();
      chk("R10 count restarted", locked, 1'b0);
      tick1();
      chk("R10 relock two ticks later", locked, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule